// File: doc/BRIEF.md
# Down-Count Timer Channel

A single timer channel that runs on the peripheral clock. It holds a down-counter, a reload register and an 8-bit control register. The surrounding bus logic writes to it through four one-cycle strobes that share one data word: an immediate load, a background load, a control write and an interrupt clear. All state can be read back in parallel.

The counter can be 16 or 32 bits wide, and the width can change while the channel is running. In 16-bit mode only the low half counts, and the upper halves of the count and reload registers keep their values. Three counting behaviours are available. A free-running count wraps to all ones. A periodic count reloads from the reload register. A one-shot count stops at zero. A programmable divider of 1, 16 or 256 paces the count. The channel raises a raw interrupt flag each time the count steps down to zero and gates that flag with an enable bit to form the masked interrupt.

Top module: `dct_timer_channel`

## Requirements
- R1: After reset the count reads 0xFFFFFFFF, the reload register reads 0, control reads 0x20, and the raw and masked flags are 0.
- R2: Control bit 7 enables counting. Bit 6 selects periodic (1) or free-running (0). Bit 5 enables the interrupt. Bits 3:2 select the divider. Bit 1 selects 32-bit (1) or 16-bit (0). Bit 0 selects one-shot. Bit 4 and bits 31:8 always read 0.
- R3: An immediate load writes the data word into both the reload register and the count at the same edge. No divider tick changes the count in that cycle.
- R4: A background load writes the reload register only. The count keeps stepping as before, and the next periodic reload uses the new value.
- R5: Divider code 0 steps the count on every cycle, code 1 every 16 cycles and codes 2 and 3 every 256 cycles. A control write restarts the divider, so the first step comes exactly N cycles after that write.
- R6: In free-running mode a step taken from zero gives all ones of the current width: 0xFFFFFFFF, or 0xFFFF in the low half for 16-bit.
- R7: In periodic mode a step taken from zero reloads from the reload register (its low half only in 16-bit mode), so the count repeats with period reload+1 steps.
- R8: In one-shot mode the count stops at zero after it reaches zero, and stays there until it is loaded or restarted.
- R9: The raw flag is set only by a step from one to zero, and the clear strobe resets it. If both happen in the same cycle, the flag is set.
- R10: The masked flag is the raw flag ANDed with control bit 5.
- R11: In 16-bit mode bits 31:16 of the count never change except through an immediate load. A later switch to 32-bit counts on from the full 32-bit value.
- R12: In periodic mode, an immediate load whose value is zero in the current width stops the count at zero. A later nonzero immediate load starts it again.
- R13: A control write with bit 7 set restarts counting, including a one-shot that has expired. While bit 7 is clear, the count is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data | input | 32 | Data word for all write strobes |
| wr_load | input | 1 | Immediate load strobe |
| wr_bgload | input | 1 | Background load strobe |
| wr_ctrl | input | 1 | Control write strobe |
| wr_intclr | input | 1 | Raw interrupt clear strobe |
| rd_value | output | 32 | Current count |
| rd_load | output | 32 | Reload register |
| rd_ctrl | output | 32 | Control register, zero-extended |
| rd_ris | output | 1 | Raw interrupt flag |
| rd_mis | output | 1 | Masked interrupt flag |

## Verification
The bench keeps the default divider exponents of 4 and 8. This lets it measure the 16- and 256-cycle step spacing exactly, including the boundary one cycle before the first step and the undefined code 3. To reach the 32-bit wrap and the 16-bit half preservation without waiting billions of cycles, the bench loads small counts and crafted upper halves.

// File: rtl/dct_pkg.sv
package dct_pkg;

  localparam int unsigned CNT_W  = 32;
  localparam int unsigned HALF_W = CNT_W / 2;
  localparam int unsigned CTRL_W = 8;

  localparam logic [CTRL_W-1:0] CTRL_WRITABLE = 8'hEF;
  localparam logic [CTRL_W-1:0] CTRL_AT_RESET = 8'h20;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic       en;
    logic       periodic;
    logic       ie;
    logic       spare;
    logic [1:0] presc;
    logic       wide;
    logic       oneshot;
  } ctrl_t;

  function automatic logic cnt_is_zero(cnt_t v, logic wide);
    return wide ? (v == '0) : (v[HALF_W-1:0] == '0);
  endfunction

  function automatic logic cnt_is_one(cnt_t v, logic wide);
    return wide ? (v == cnt_t'(1)) : (v[HALF_W-1:0] == HALF_W'(1));
  endfunction

  // Value after one divider step; the upper half is untouched in 16-bit mode.
  function automatic cnt_t cnt_step(cnt_t v, cnt_t rld, logic wide, logic periodic);
    cnt_t nxt;
    if (cnt_is_zero(v, wide)) nxt = periodic ? rld : '1;
    else                      nxt = v - cnt_t'(1);
    return wide ? nxt : {v[CNT_W-1:HALF_W], nxt[HALF_W-1:0]};
  endfunction

  // Terminal count of the divider for a given code.
  function automatic int unsigned div_last(logic [1:0] code, int unsigned mid_log2,
                                           int unsigned hi_log2);
    case (code)
      2'd0:    return 0;
      2'd1:    return (1 << mid_log2) - 1;
      default: return (1 << hi_log2) - 1;
    endcase
  endfunction

endpackage

// File: rtl/dct_ctrl_reg.sv
module dct_ctrl_reg
  import dct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] data_i,
  output ctrl_t             ctrl_o
);

  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctrl_q <= CTRL_AT_RESET;
    else if (wr_i) ctrl_q <= data_i & CTRL_WRITABLE;
  end

  assign ctrl_o = ctrl_t'(ctrl_q);

endmodule

// File: rtl/dct_prescaler.sv
module dct_prescaler
  import dct_pkg::*;
#(
  parameter int unsigned MID_LOG2 = 4,
  parameter int unsigned HI_LOG2  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart_i,
  input  logic [1:0] code_i,
  output logic       tick_o
);

  localparam int unsigned DIV_W = (HI_LOG2 > MID_LOG2) ? HI_LOG2 : MID_LOG2;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_lim;

  assign div_lim = DIV_W'(div_last(code_i, MID_LOG2, HI_LOG2));
  assign tick_o  = (div_q == div_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   div_q <= '0;
    else if (restart_i || tick_o) div_q <= '0;
    else                          div_q <= div_q + DIV_W'(1);
  end

  // R5: with a divider above one, two ticks are never adjacent
  assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && code_i != 2'd0 && !restart_i) |=> !tick_o);

endmodule

// File: rtl/dct_counter.sv
module dct_counter
  import dct_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic periodic_i,
  input  logic wide_i,
  input  logic oneshot_i,
  input  logic tick_i,
  input  cnt_t wr_data_i,
  input  logic wr_load_i,
  input  logic wr_bgload_i,
  input  logic wr_ctrl_i,
  input  logic restart_i,
  output cnt_t value_o,
  output cnt_t load_o,
  output logic hit_o,
  output logic zero_o
);

  cnt_t value_q, load_q;
  logic halt_q;
  logic step_en;

  assign step_en = en_i && !halt_q && tick_i && !wr_load_i && !wr_ctrl_i;
  assign hit_o   = step_en && cnt_is_one(value_q, wide_i);
  assign zero_o  = cnt_is_zero(value_q, wide_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '1;
      load_q  <= '0;
      halt_q  <= 1'b0;
    end else begin
      if (wr_load_i) begin
        value_q <= wr_data_i;
        halt_q  <= periodic_i && cnt_is_zero(wr_data_i, wide_i);
      end else if (step_en) begin
        value_q <= cnt_step(value_q, load_q, wide_i, periodic_i);
        if (hit_o && oneshot_i) halt_q <= 1'b1;
      end else if (restart_i) begin
        halt_q <= 1'b0;
      end
      if (wr_load_i || wr_bgload_i) load_q <= wr_data_i;
    end
  end

  assign value_o = value_q;
  assign load_o  = load_q;

  // R13: disabled channel keeps its count unless loaded
  assert_frozen_when_off_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !wr_load_i) |=> $stable(value_q));

  // R8: an expired one-shot holds until loaded or restarted
  assert_oneshot_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !wr_load_i && !restart_i) |=> $stable(value_q));

  // R11: upper half of the count survives 16-bit operation
  assert_upper_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_i && !wr_load_i) |=> (value_q[CNT_W-1:HALF_W] == $past(value_q[CNT_W-1:HALF_W])));

  // R4: background load with no tick leaves the count alone
  assert_bgload_keeps_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bgload_i && !wr_load_i && !tick_i) |=> $stable(value_q));

  // R3: immediate load lands in the count at once
  assert_load_immediate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load_i |=> (value_q == $past(wr_data_i)));

endmodule

// File: rtl/dct_irq_flag.sv
module dct_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic clr_i,
  output logic ris_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ris_o <= 1'b0;
    else if (hit_i) ris_o <= 1'b1;
    else if (clr_i) ris_o <= 1'b0;
  end

  // R9: a clear with no concurrent hit drops the flag
  assert_clear_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !hit_i) |=> !ris_o);

  // R9: a hit always raises the flag, even against a clear
  assert_hit_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> ris_o);

endmodule

// File: rtl/dct_timer_channel.sv
module dct_timer_channel
  import dct_pkg::*;
#(
  parameter int unsigned DIV_MID_LOG2 = 4,
  parameter int unsigned DIV_HI_LOG2  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] wr_data,
  input  logic        wr_load,
  input  logic        wr_bgload,
  input  logic        wr_ctrl,
  input  logic        wr_intclr,
  output logic [31:0] rd_value,
  output logic [31:0] rd_load,
  output logic [31:0] rd_ctrl,
  output logic        rd_ris,
  output logic        rd_mis
);

  ctrl_t ctrl;
  logic  tick;
  logic  hit;
  logic  cnt_zero;
  logic  restart;
  cnt_t  value, load;

  assign restart = wr_ctrl && wr_data[7];

  dct_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (wr_ctrl),
    .data_i (wr_data[CTRL_W-1:0]),
    .ctrl_o (ctrl)
  );

  dct_prescaler #(
    .MID_LOG2 (DIV_MID_LOG2),
    .HI_LOG2  (DIV_HI_LOG2)
  ) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (wr_ctrl),
    .code_i    (ctrl.presc),
    .tick_o    (tick)
  );

  dct_counter u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (ctrl.en),
    .periodic_i  (ctrl.periodic),
    .wide_i      (ctrl.wide),
    .oneshot_i   (ctrl.oneshot),
    .tick_i      (tick),
    .wr_data_i   (wr_data),
    .wr_load_i   (wr_load),
    .wr_bgload_i (wr_bgload),
    .wr_ctrl_i   (wr_ctrl),
    .restart_i   (restart),
    .value_o     (value),
    .load_o      (load),
    .hit_o       (hit),
    .zero_o      (cnt_zero)
  );

  dct_irq_flag u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .hit_i (hit),
    .clr_i (wr_intclr),
    .ris_o (rd_ris)
  );

  assign rd_value = value;
  assign rd_load  = load;
  assign rd_ctrl  = {{(32-CTRL_W){1'b0}}, ctrl};
  assign rd_mis   = rd_ris && ctrl.ie;

  // R9: the raw flag only rises with the count sitting at zero
  assert_rise_at_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_ris) |-> cnt_zero);

endmodule

// File: tb/dct_timer_channel_bench.sv
module dct_timer_channel_bench;

  localparam int S_LOAD = 0;
  localparam int S_BG   = 1;
  localparam int S_CTRL = 2;
  localparam int S_CLR  = 3;
  localparam int NV     = 12;

  // control byte (enable added by arm), load, cycles, expected count, expected raw flag
  localparam logic [7:0]  V_CTRL [NV] = '{8'h62, 8'h62, 8'h22, 8'h20, 8'h63, 8'h21,
                                          8'h66, 8'h6A, 8'h6E, 8'h60, 8'h66, 8'h66};
  localparam logic [31:0] V_LOAD [NV] = '{32'd5, 32'd5, 32'd2, 32'h12340002, 32'd3,
                                          32'hABCD0001, 32'd100, 32'd100, 32'd100,
                                          32'h00070003, 32'd10, 32'd10};
  localparam int          V_CYC  [NV] = '{3, 6, 3, 3, 10, 5, 40, 600, 511, 5, 16, 15};
  localparam logic [31:0] V_VAL  [NV] = '{32'd2, 32'd5, 32'hFFFFFFFF, 32'h1234FFFF, 32'd0,
                                          32'hABCD0000, 32'd98, 32'd98, 32'd99,
                                          32'h00070002, 32'd9, 32'd10};
  localparam logic        V_RIS  [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
                                          1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam string       V_TAG  [NV] = '{"R7", "R7", "R6", "R6", "R8", "R8",
                                          "R5", "R5", "R5", "R11", "R5", "R5"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_load = 1'b0, wr_bgload = 1'b0, wr_ctrl = 1'b0, wr_intclr = 1'b0;
  logic [31:0] rd_value, rd_load, rd_ctrl;
  logic        rd_ris, rd_mis;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] snap;

  always #5 clk = ~clk;

  dct_timer_channel u_dct_timer_channel (
    .clk (clk), .rst_n (rst_n), .wr_data (wr_data),
    .wr_load (wr_load), .wr_bgload (wr_bgload), .wr_ctrl (wr_ctrl), .wr_intclr (wr_intclr),
    .rd_value (rd_value), .rd_load (rd_load), .rd_ctrl (rd_ctrl),
    .rd_ris (rd_ris), .rd_mis (rd_mis)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_write(input int sel, input logic [31:0] d);
    @(negedge clk);
    wr_data = d;
    case (sel)
      S_LOAD:  wr_load   = 1'b1;
      S_BG:    wr_bgload = 1'b1;
      S_CTRL:  wr_ctrl   = 1'b1;
      default: wr_intclr = 1'b1;
    endcase
    @(negedge clk);
    wr_load = 1'b0; wr_bgload = 1'b0; wr_ctrl = 1'b0; wr_intclr = 1'b0;
  endtask

  task automatic arm(input logic [7:0] c, input logic [31:0] ld);
    do_write(S_CTRL, {24'h0, c & 8'h7F});
    do_write(S_LOAD, ld);
    do_write(S_CLR, 32'h0);
    do_write(S_CTRL, {24'h0, c | 8'h80});
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung run, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", rd_value, 32'hFFFFFFFF);
    chk("R1", rd_load, 32'h0);
    chk("R1", rd_ctrl, 32'h20);
    chk("R1", {30'h0, rd_ris, rd_mis}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      arm(V_CTRL[i], V_LOAD[i]);
      repeat (V_CYC[i]) @(negedge clk);
      chk(V_TAG[i], rd_value, V_VAL[i]);
      chk(V_TAG[i], {31'h0, rd_ris}, {31'h0, V_RIS[i]});
    end

    // R3: immediate load; R12: periodic zero load stops, nonzero restarts
    arm(8'h62, 32'd50);
    do_write(S_LOAD, 32'd0);
    chk("R12", rd_value, 32'd0);
    repeat (5) @(negedge clk);
    chk("R12", rd_value, 32'd0);
    chk("R12", {31'h0, rd_ris}, 32'h0);
    do_write(S_LOAD, 32'd4);
    chk("R3", rd_value, 32'd4);
    chk("R3", rd_load, 32'd4);
    repeat (2) @(negedge clk);
    chk("R12", rd_value, 32'd2);

    // R4: background load keeps the count, next reload uses it
    arm(8'h62, 32'd3);
    do_write(S_BG, 32'd10);
    chk("R4", rd_value, 32'd1);
    chk("R4", rd_load, 32'd10);
    @(negedge clk);
    chk("R4", rd_value, 32'd0);
    @(negedge clk);
    chk("R4", rd_value, 32'd10);

    // R9: a hit in the same cycle as a clear leaves the flag set
    arm(8'h62, 32'd1);
    wr_intclr = 1'b1;
    @(negedge clk);
    wr_intclr = 1'b0;
    chk("R9", {31'h0, rd_ris}, 32'h1);

    // R13: clearing enable freezes the count
    arm(8'h62, 32'd100);
    repeat (5) @(negedge clk);
    do_write(S_CTRL, 32'h62);
    chk("R13", rd_value, 32'd94);
    repeat (5) @(negedge clk);
    chk("R13", rd_value, 32'd94);

    // R8 then R13: expired one-shot resumes after control write with enable
    arm(8'h63, 32'd3);
    repeat (10) @(negedge clk);
    chk("R8", rd_value, 32'd0);
    do_write(S_CTRL, 32'hE3);
    chk("R13", rd_value, 32'd0);
    repeat (2) @(negedge clk);
    chk("R13", rd_value, 32'd2);

    // R10: masking, then R9 clear alone
    do_write(S_CTRL, 32'h43);
    snap = rd_value;
    chk("R10", {30'h0, rd_ris, rd_mis}, 32'h2);
    do_write(S_CTRL, 32'h63);
    chk("R10", {30'h0, rd_ris, rd_mis}, 32'h3);
    do_write(S_CLR, 32'h0);
    chk("R9", {30'h0, rd_ris, rd_mis}, 32'h0);
    chk("R13", rd_value, snap);

    // R11: upper half kept in 16-bit one-shot, then counted on in 32-bit
    arm(8'h21, 32'h00050002);
    repeat (5) @(negedge clk);
    chk("R11", rd_value, 32'h00050000);
    do_write(S_CTRL, 32'hA2);
    chk("R11", rd_value, 32'h00050000);
    @(negedge clk);
    chk("R11", rd_value, 32'h0004FFFF);
    chk("R11", rd_load, 32'h00050002);

    // R2: unused control bits read zero
    do_write(S_CTRL, 32'hFFFFFF7F);
    chk("R2", rd_ctrl, 32'h6F);

    finish_run();
  end

endmodule